// File: doc/BRIEF.md
# Sectioned Configuration Shift Chain

This block holds the static settings of a front-end channel array and takes them from a single serial line. One long shift register is split into two sections. The section nearest the serial output carries the global reference codes that steer the bias generators. The section behind it carries one small field per channel: a disable flag, a test-charge enable flag and a threshold trim value. Each independent tier of a detector stack gets its own copy of the block.

Bits enter on `sdi` on every clock with `shift_en` high. They leave on `sdo`, so several chains can be cascaded or read back by shifting. A single `load` pulse copies the whole chain, in one cycle, into four separate shadow destinations: reference codes, disable flags, inject flags and trims. The outputs of these destinations are the live settings. They do not move while new data is shifted in.

Top module: `cfg_chain`

## Requirements
- R1: While `rst_n` is low, all shadow outputs are zero (no channel disabled, no inject, zero trim, all codes zero) and `sdo` is 0.
- R2: On each clock with `shift_en` high the chain moves one place towards the output. `sdi` enters the far end and `sdo` shows chain bit 0, so a bit appears on `sdo` exactly 384 enabled clocks after it was presented. With `shift_en` low the chain and `sdo` hold.
- R3: Shadow outputs change only on a clock with `load` high. Shifting alone never alters them.
- R4: On load, reference code k (k = 0..7, 8 bits each) takes chain bits [8k+7:8k]. Code k appears on `dac_codes[8k+7:8k]`. Data is sent LSB-first, so the first bit shifted in ends at chain bit 0.
- R5: On load, channel c (c = 0..63) takes its 5-bit field at chain base 64+5c. Bit base+0 goes to the disable flag `ch_kill[c]`, base+1 to the inject flag `ch_inject[c]`, and base+2..base+4 to trim `ch_trim[3c+2:3c]`.
- R6: When `load` and `shift_en` are high in the same clock, the shadows capture the chain contents from before that shift.
- R7: A load leaves the chain contents untouched, so the loaded pattern can be shifted back out on `sdo` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift the chain by one bit this cycle |
| sdi | input | 1 | Serial data into the far end of the chain |
| load | input | 1 | Copy chain into all shadow destinations |
| sdo | output | 1 | Serial data out, chain bit 0 |
| dac_codes | output | 64 | Eight 8-bit reference codes, code k at [8k+7:8k] |
| ch_kill | output | 64 | Per-channel disable flags |
| ch_inject | output | 64 | Per-channel test-charge enables |
| ch_trim | output | 192 | Per-channel 3-bit trims, channel c at [3c+2:3c] |

## Verification
The bench aims at field placement. It uses patterns that differ across neighbouring bits, so a chain reversed or shifted by one bit, or a channel field with kill and inject swapped, would put the wrong values on the decoded outputs. It checks that shadows hold while a fresh pattern shifts in, and that the old pattern comes back out on `sdo` in order. A design that let shadows follow the chain, or that changed the chain on load, would fail there. It also raises load and shift in the same cycle, where a design capturing the post-shift value would be off by one bit. Finally it toggles `sdi` with shift disabled, which catches a chain that shifts without enable.

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int NUM_DAC = 8,
  parameter int DAC_W   = 8,
  parameter int NUM_CH  = 64,
  parameter int TRIM_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic                       sdi,
  input  logic                       load,
  output logic                       sdo,
  output logic [NUM_DAC*DAC_W-1:0]   dac_codes,
  output logic [NUM_CH-1:0]          ch_kill,
  output logic [NUM_CH-1:0]          ch_inject,
  output logic [NUM_CH*TRIM_W-1:0]   ch_trim
);
  localparam int DAC_BITS  = NUM_DAC * DAC_W;
  localparam int CH_W      = 2 + TRIM_W;
  localparam int CHAIN_LEN = DAC_BITS + NUM_CH * CH_W;

  logic [CHAIN_LEN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (shift_en) chain_q <= {sdi, chain_q[CHAIN_LEN-1:1]};
  end

  assign sdo = chain_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dac_codes <= '0;
    else if (load) dac_codes <= chain_q[DAC_BITS-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = DAC_BITS + c * CH_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_kill[c]                  <= 1'b0;
        ch_inject[c]                <= 1'b0;
        ch_trim[c*TRIM_W +: TRIM_W] <= '0;
      end else if (load) begin
        ch_kill[c]                  <= chain_q[BASE];
        ch_inject[c]                <= chain_q[BASE+1];
        ch_trim[c*TRIM_W +: TRIM_W] <= chain_q[BASE+2 +: TRIM_W];
      end
    end
  end
endmodule

// File: rtl/cfg_chain_sva.sv
module cfg_chain_sva #(
  parameter int CHAIN_LEN = 384,
  parameter int DAC_BITS  = 64,
  parameter int NUM_CH    = 64,
  parameter int TRIM_W    = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     shift_en,
  input logic                     load,
  input logic                     sdo,
  input logic [CHAIN_LEN-1:0]     chain_q,
  input logic [DAC_BITS-1:0]      dac_codes,
  input logic [NUM_CH-1:0]        ch_kill,
  input logic [NUM_CH-1:0]        ch_inject,
  input logic [NUM_CH*TRIM_W-1:0] ch_trim
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_codes == '0 && ch_kill == '0 && ch_inject == '0 && ch_trim == '0 && !sdo));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sdo));

  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sdo == $past(chain_q[1]));

  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dac_codes) && $stable(ch_kill) && $stable(ch_inject) && $stable(ch_trim)));
endmodule

bind cfg_chain cfg_chain_sva #(
  .CHAIN_LEN(CHAIN_LEN), .DAC_BITS(DAC_BITS), .NUM_CH(NUM_CH), .TRIM_W(TRIM_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load(load), .sdo(sdo),
  .chain_q(chain_q), .dac_codes(dac_codes), .ch_kill(ch_kill),
  .ch_inject(ch_inject), .ch_trim(ch_trim)
);

// File: tb/cfg_chain_test.sv
module cfg_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;
  localparam int DB  = 64;
  localparam int LEN = DB + NCH * 5;

  logic clk = 1'b0, rst_n = 1'b0, shift_en = 1'b0, sdi = 1'b0, load = 1'b0;
  logic sdo;
  logic [DB-1:0]    dac_codes;
  logic [NCH-1:0]   ch_kill, ch_inject;
  logic [NCH*3-1:0] ch_trim;

  int n_tests = 0, n_fail = 0;
  logic [LEN-1:0] pat_a, pat_b, pat_c;

  cfg_chain uut (.clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi), .load(load),
    .sdo(sdo), .dac_codes(dac_codes), .ch_kill(ch_kill), .ch_inject(ch_inject), .ch_trim(ch_trim));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_shadows(input string req, input logic [LEN-1:0] v);
    logic [NCH-1:0] k, inj;
    logic [NCH*3-1:0] tr;
    for (int c = 0; c < NCH; c++) begin
      k[c]       = v[DB + 5*c];
      inj[c]     = v[DB + 5*c + 1];
      tr[3*c +: 3] = v[DB + 5*c + 2 +: 3];
    end
    chk({req, "/R4"}, "dac_codes", 256'(dac_codes), 256'(v[DB-1:0]));
    chk({req, "/R5"}, "ch_kill", 256'(ch_kill), 256'(k));
    chk({req, "/R5"}, "ch_inject", 256'(ch_inject), 256'(inj));
    chk({req, "/R5"}, "ch_trim", 256'(ch_trim), 256'(tr));
  endtask

  task automatic shift_in(input logic [LEN-1:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi = v[i]; shift_en = 1'b1; step();
    end
    shift_en = 1'b0; sdi = 1'b0;
  endtask

  task automatic do_load();
    load = 1'b1; step(); load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "sdo", 256'(sdo), 256'(0));
    check_shadows("R1", '0);
    rst_n = 1'b1; step();
  endtask

  task automatic t_shift_no_load();
    shift_in(pat_a, LEN);
    check_shadows("R3", '0);
  endtask

  task automatic t_load();
    do_load();
    check_shadows("R4_R5", pat_a);
  endtask

  task automatic t_readback();
    int bad = 0;
    for (int i = 0; i < LEN; i++) begin
      if (sdo !== pat_a[i]) bad++;
      sdi = pat_b[i]; shift_en = 1'b1; step();
    end
    shift_en = 1'b0;
    chk("R7/R2", "readback mismatches", 256'(bad), 256'(0));
    check_shadows("R3", pat_a);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 12; i++) begin
      sdi = i[0]; step();
    end
    do_load();
    check_shadows("R2_idle", pat_b);
  endtask

  task automatic t_load_with_shift();
    logic [LEN-1:0] pre;
    shift_in(pat_c, LEN - 1);
    pre = {pat_c[LEN-2:0], pat_b[LEN-1]};
    sdi = pat_c[LEN-1]; shift_en = 1'b1; load = 1'b1; step();
    shift_en = 1'b0; load = 1'b0;
    check_shadows("R6", pre);
    do_load();
    check_shadows("R6_after", pat_c);
  endtask

  task automatic t_reset_again();
    rst_n = 1'b0; #2;
    chk("R1", "sdo mid reset", 256'(sdo), 256'(0));
    check_shadows("R1", '0);
    step(); rst_n = 1'b1; step();
  endtask

  initial begin
    for (int i = 0; i < LEN; i++) begin
      pat_a[i] = (((i * 7 + 3) % 5) == 0) ^ ((i % 3) == 0);
      pat_c[i] = ((i % 11) < 5);
    end
    pat_b = ~pat_a;
    #3;
    t_reset();
    t_shift_no_load();
    t_load();
    t_readback();
    t_idle();
    t_load_with_shift();
    t_reset_again();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule